// File: doc/BRIEF.md
# Alarm Match and Interrupt Status Register

This block sits beside a real-time clock's time counters. It holds three alarm bytes (seconds, minutes, hours). It compares them with the current time fields whenever the counters report a finished update. It also keeps the byte that software reads to learn why an interrupt occurred.

Three single-cycle events set status bits: the update-done pulse, the periodic pulse and an alarm match. Each bit sets whether or not its source is enabled. A summary bit and an active-low interrupt line report only the sources whose enable is on. Software reads the status byte with a read strobe, and that read clears every bit. Any alarm field whose two top bits are both set acts as a wildcard.

Top module: `rtc_alarm_irq`

## Requirements
- R1: A write with `wr_en` high loads the seconds alarm at index 1, the minutes alarm at index 3 and the hours alarm at index 5. A write to any other index changes no alarm. All alarms reset to 0x00.
- R2: An alarm field whose bits 7 and 6 are both 1 matches any time value. Any other field matches only a time value equal to it.
- R3: The alarm bit (`flags` bit 5) sets in the cycle after an `upd_pulse` during which all three fields match. A match without `upd_pulse` does not set it.
- R4: `upd_pulse` sets the update bit (`flags` bit 4) one cycle later. `per_pulse` sets the periodic bit (`flags` bit 6) one cycle later.
- R5: Bits 6, 5 and 4 set no matter what `src_en` holds.
- R6: `flags` bit 7 is 1 exactly when some source bit is 1 and its enable is on. `src_en[2]` enables periodic, `src_en[1]` alarm and `src_en[0]` update. `irq_n` is the inverse of bit 7, in the same cycle.
- R7: A cycle with `flag_rd` high clears bits 6 to 4 at the next edge. An event in the same cycle as the read wins, so its bit is set after the read.
- R8: Bits 3 to 0 of `flags` are always 0. After reset `flags` is 0x00 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Alarm register write strobe |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 8 | Write data |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hr | input | 8 | Current hours |
| upd_pulse | input | 1 | Update-done event, one cycle |
| per_pulse | input | 1 | Periodic event, one cycle |
| src_en | input | 3 | Enables: [2] periodic, [1] alarm, [0] update |
| flag_rd | input | 1 | Status read strobe, clears on read |
| flags | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A corrupted alarm byte shows up only at the next update pulse: the alarm bit fails to set or sets when it should not, one cycle after that pulse. A status bit that is stuck, or that is not cleared, is visible in `flags` in the very next cycle after its event or read. If the bit's source is enabled, it also shows on `irq_n` in that cycle. A faulty enable gate shows only while a source bit is set, so the bench sets each source with different enable patterns.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int STAT_W  = 8;
   localparam int POS_IRQ = 7;
   localparam int POS_PER = 6;
   localparam int POS_ALM = 5;
   localparam int POS_UPD = 4;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } src_bits_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] alarm_val,
   input  logic [DW-1:0] time_val,
   output logic          hit
);
   initial begin
      if (DW < 2) $error("alarm_field_cmp: DW must be at least 2");
   end

   logic wild;
   always_comb begin
      wild = &alarm_val[DW-1:DW-2];
      hit  = wild | (alarm_val == time_val);
   end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs #(
   parameter int DW    = 8,
   parameter int NF    = 3,
   parameter int IDX_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [DW-1:0]         wr_data,
   output logic [NF-1:0][DW-1:0] alm
);
   initial begin
      if ((2 * NF) >= (1 << IDX_W)) $error("alarm_regs: IDX_W too small for NF fields");
   end

   logic [NF-1:0] sel;

   for (genvar g = 0; g < NF; g++) begin : g_fld
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(2 * g + 1);
      assign sel[g] = wr_en && (wr_idx == MY_IDX);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      alm[g] <= '0;
         else if (sel[g]) alm[g] <= wr_data;
      end
   end

   // R1: a write that addresses no alarm field leaves all alarms unchanged
   assert_ignore_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel == '0)) |=> $stable(alm));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import rtc_alarm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              per_evt,
   input  logic              alm_evt,
   input  logic              upd_evt,
   input  logic              rd_clr,
   input  logic [2:0]        en,
   output logic [STAT_W-1:0] flags,
   output logic              irq_n
);
   src_bits_t src_q, src_d;
   logic      summary;

   always_comb begin
      src_d = rd_clr ? '0 : src_q;
      src_d.per = src_d.per | per_evt;
      src_d.alm = src_d.alm | alm_evt;
      src_d.upd = src_d.upd | upd_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_d;
   end

   always_comb begin
      summary = (src_q.per & en[2]) | (src_q.alm & en[1]) | (src_q.upd & en[0]);
      flags          = '0;
      flags[POS_IRQ] = summary;
      flags[POS_PER] = src_q.per;
      flags[POS_ALM] = src_q.alm;
      flags[POS_UPD] = src_q.upd;
      irq_n          = ~summary;
   end

   assert_upd_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> src_q.upd);
   assert_per_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      per_evt |=> src_q.per);
   assert_alm_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alm_evt |=> src_q.alm);
   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !per_evt && !alm_evt && !upd_evt) |=> (src_q == '0));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && !per_evt && !alm_evt && !upd_evt) |=> $stable(src_q));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int DW    = 8,
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DW-1:0]     wr_data,
   input  logic [DW-1:0]     cur_sec,
   input  logic [DW-1:0]     cur_min,
   input  logic [DW-1:0]     cur_hr,
   input  logic              upd_pulse,
   input  logic              per_pulse,
   input  logic [2:0]        src_en,
   input  logic              flag_rd,
   output logic [STAT_W-1:0] flags,
   output logic              irq_n
);
   localparam int NF = 3;

   logic [NF-1:0][DW-1:0] alm;
   logic [NF-1:0][DW-1:0] now;
   logic [NF-1:0]         hits;
   logic                  alm_evt;

   assign now[0] = cur_sec;
   assign now[1] = cur_min;
   assign now[2] = cur_hr;

   alarm_regs #(.DW(DW), .NF(NF), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .alm(alm));

   for (genvar g = 0; g < NF; g++) begin : g_cmp
      alarm_field_cmp #(.DW(DW)) u_cmp (
         .alarm_val(alm[g]), .time_val(now[g]), .hit(hits[g]));

      // R2: a wildcard field always reports a hit
      assert_wildcard_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (&alm[g][DW-1:DW-2]) |-> hits[g]);
   end

   assign alm_evt = upd_pulse & (&hits);

   irq_flag_reg u_flags (
      .clk(clk), .rst_n(rst_n), .per_evt(per_pulse), .alm_evt(alm_evt),
      .upd_evt(upd_pulse), .rd_clr(flag_rd), .en(src_en),
      .flags(flags), .irq_n(irq_n));

   // R3: without an update pulse the alarm bit cannot rise
   assert_no_alarm_without_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pulse |=> !$rose(flags[POS_ALM]));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_idx = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
   logic       upd_pulse = 1'b0, per_pulse = 1'b0, flag_rd = 1'b0;
   logic [2:0] src_en = '0;
   logic [7:0] flags;
   logic       irq_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rtc_alarm_irq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
      .upd_pulse(upd_pulse), .per_pulse(per_pulse), .src_en(src_en),
      .flag_rd(flag_rd), .flags(flags), .irq_n(irq_n));

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [7:0] d);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
      cur_sec = s; cur_min = m; cur_hr = h;
   endtask

   task automatic upd();
      upd_pulse = 1'b1; step(); upd_pulse = 1'b0;
   endtask

   task automatic clr();
      flag_rd = 1'b1; step(); flag_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R8 reset", {irq_n, flags}, {1'b1, 8'h00});
   endtask

   task automatic t_exact_match();
      wr(4'd1, 8'h10); wr(4'd3, 8'h20); wr(4'd5, 8'h05);
      set_time(8'h10, 8'h20, 8'h05); upd();
      chk("R3 exact match", {irq_n, flags}, {1'b1, 8'h30});
      clr();
      chk("R7 cleared", {irq_n, flags}, {1'b1, 8'h00});
      // R1: indices 0, 2, 4 and 6 must not touch the alarms
      wr(4'd0, 8'h99); wr(4'd2, 8'h99); wr(4'd4, 8'h99); wr(4'd6, 8'h99);
      upd();
      chk("R1 other index ignored", {irq_n, flags}, {1'b1, 8'h30});
      clr();
   endtask

   task automatic t_mismatch();
      set_time(8'h11, 8'h20, 8'h05); upd();
      chk("R3 mismatch", {irq_n, flags}, {1'b1, 8'h10});
      clr();
      set_time(8'h10, 8'h20, 8'h05); step(); step();
      chk("R3 match without update", {irq_n, flags}, {1'b1, 8'h00});
   endtask

   task automatic t_wildcard();
      wr(4'd1, 8'hC0); set_time(8'h37, 8'h20, 8'h05); upd();
      chk("R2 wildcard C0", flags, 8'h30);
      clr();
      wr(4'd3, 8'hFF); set_time(8'h01, 8'h59, 8'h05); upd();
      chk("R2 wildcard FF", flags, 8'h30);
      clr();
      wr(4'd1, 8'h80); set_time(8'h37, 8'h59, 8'h05); upd();
      chk("R2 bit7 only not wildcard", flags, 8'h10);
      clr();
      wr(4'd5, 8'h40); set_time(8'h80, 8'h00, 8'h40); wr(4'd1, 8'h80); upd();
      chk("R2 bit6 only exact", flags, 8'h30);
      clr();
   endtask

   task automatic t_enables();
      src_en = 3'b000;
      per_pulse = 1'b1; step(); per_pulse = 1'b0;
      chk("R5 periodic disabled still sets", {irq_n, flags}, {1'b1, 8'h40});
      src_en = 3'b011; #1;
      chk("R6 other enables no summary", {irq_n, flags}, {1'b1, 8'h40});
      src_en = 3'b100; #1;
      chk("R6 periodic enabled", {irq_n, flags}, {1'b0, 8'hC0});
      clr();
      chk("R7 read clears irq", {irq_n, flags}, {1'b1, 8'h00});
      src_en = 3'b001; set_time(8'h00, 8'h00, 8'h00); upd();
      chk("R6 update enabled", {irq_n, flags}, {1'b0, 8'h90});
      clr();
      src_en = 3'b010; wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0); upd();
      chk("R6 alarm enabled", {irq_n, flags}, {1'b0, 8'hB0});
      clr();
      src_en = 3'b000;
   endtask

   task automatic t_read_race();
      flag_rd = 1'b1; per_pulse = 1'b1;
      step();
      flag_rd = 1'b0; per_pulse = 1'b0;
      chk("R7 event wins over read", flags, 8'h40);
      upd_pulse = 1'b1; step(); upd_pulse = 1'b0;
      chk("R4 update flag added", flags, 8'h70);
      flag_rd = 1'b1; #1;
      chk("R7 value visible during read", flags, 8'h70);
      chk("R8 low nibble zero", {5'd0, flags[3:0]}, 9'd0);
      step(); flag_rd = 1'b0;
      chk("R7 all cleared", flags, 8'h00);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_exact_match();
      t_mismatch();
      t_wildcard();
      t_enables();
      t_read_race();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule